// File: doc/BRIEF.md
# Cached DRAM Row-Register Controller

This block is a synchronous model of a DRAM core with a single SRAM row register in front of it. A last-row-read tag records which core row the register currently mirrors. Commands arrive as active-low strobes sampled on the rising clock. A high-to-low change of the row-enable strobe starts an operation. The operation type is decoded from the refresh strobe and the write/read mode input. The incoming row address is compared against the tag, which gives a read hit, a read miss (row fill), a write hit (core and register both updated) or a write miss (core only).

Reads always come from the row register, addressed by the column, whether or not row-enable is active. This lets a controller keep reading during precharge or refresh. A transparent column latch lets the column be held, or be followed directly. The register is split into four lanes, and the top column bits pick the lane that feeds the 1-bit output. The core size, the lane count and the write-miss recovery delay are parameters.

Top module: `cdr_row_ctrl`

## Requirements
- R1: After reset the output is enabled whenever select and output-enable are low, and it reads 0. The tag is marked invalid, so the first operation to any row, row 0 included, is a miss.
- R2: A row-enable fall with `rfsh_n` low is a refresh. Neither the tag nor the row register changes, whatever `wr_mode` and `addr` are.
- R3: A row-enable fall with `rfsh_n` high and `wr_mode` 0 is a read. If the row differs from the tag, or the tag is invalid, the whole core row is copied into the row register and the tag is loaded. The new data is visible in the cycle after the fall.
- R4: A read whose row equals the valid tag leaves the row register as it is, and reads return its contents.
- R5: A row-enable fall with `rfsh_n` high and `wr_mode` 1 is a write. If the row equals the valid tag, each write updates the core and the row register together. Reads stay enabled during the write, and they show the new bit.
- R6: A write whose row misses the tag updates the core only. The row register and the tag are unchanged, and the written data only becomes visible after a later read miss of that row.
- R7: Inside a write operation, a bit is written only on a clock edge where both `col_lat_n` and `we_n` are low.
- R8: From the edge of a write-miss fall, `dout_en` is 0 even with `oe_n` low. It returns after RECOV rising edges sampled with `row_en_n` high.
- R9: `dout_en` is 1 exactly when `sel_n` and `oe_n` are low and no write-miss block is pending. `dout` is then the register bit at the effective column, otherwise 0. This holds with row-enable inactive.
- R10: The effective column follows `addr` while `col_lat_n` is high. While it is low, the column sampled on the last edge with `col_lat_n` high is held. Column bits [CW-1:CW-2] select the lane.
- R11: A row-enable fall with `sel_n` high and `rfsh_n` high is ignored: no fill, no tag change and no writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_en_n | input | 1 | Row-enable strobe; a fall starts an operation and latches the row |
| rfsh_n | input | 1 | Refresh request, sampled on the row-enable fall |
| wr_mode | input | 1 | 1 = write operation, 0 = read operation |
| sel_n | input | 1 | Chip select, active low |
| col_lat_n | input | 1 | Column latch: high is transparent, low holds |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | AW | Row address at the fall, column address otherwise |
| din | input | 1 | Write data |
| dout | output | 1 | Read data (0 when disabled) |
| dout_en | output | 1 | Output driven |

## Verification
The outputs are combinational from the row register, the block flag and the present inputs. A column or gating change therefore shows up in the same cycle. A fill, a write or a block flag takes effect on the edge that samples the strobe, and so shows up in the following cycle. Write-miss release comes RECOV edges after row-enable is first sampled high. The bench drives inputs 1 ns after a rising edge, updates its own model at that edge, and compares at the falling edge. In this way every check sees exactly the edges the model has already applied.

// File: rtl/cdr_pkg.sv
package cdr_pkg;
   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2,
      OP_RFSH  = 2'd3
   } cdr_op_e;
endpackage

// File: rtl/cdr_core_array.sv
module cdr_core_array #(
   parameter int ROWS = 16,
   parameter int COLS = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we,
   input  logic [$clog2(ROWS)-1:0]  wr_row,
   input  logic [$clog2(COLS)-1:0]  wr_col,
   input  logic                     wr_bit,
   input  logic [$clog2(ROWS)-1:0]  rd_row,
   output logic [COLS-1:0]          rd_bits
);
   logic [ROWS-1:0][COLS-1:0] mem_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  mem_q <= '0;
      else if (we) mem_q[wr_row][wr_col] <= wr_bit;
   end

   assign rd_bits = mem_q[rd_row];
endmodule

// File: rtl/cdr_row_cache.sv
module cdr_row_cache #(
   parameter int COLS  = 16,
   parameter int LANES = 4,
   parameter int RW    = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     fill,
   input  logic [RW-1:0]            fill_row,
   input  logic [COLS-1:0]          fill_bits,
   input  logic                     wr_en,
   input  logic [$clog2(COLS)-1:0]  wr_col,
   input  logic                     wr_bit,
   input  logic [$clog2(COLS)-1:0]  rd_col,
   output logic                     rd_bit,
   output logic [RW-1:0]            lrr,
   output logic                     lrr_valid,
   output logic [COLS-1:0]          row_bits
);
   localparam int CW    = $clog2(COLS);
   localparam int LB    = $clog2(LANES);
   localparam int DEPTH = COLS / LANES;
   localparam int OB    = $clog2(DEPTH);

   logic [LANES-1:0] lane_out;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [DEPTH-1:0] lane_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            lane_q <= '0;
         else if (fill)
            lane_q <= fill_bits[l*DEPTH +: DEPTH];
         else if (wr_en && wr_col[CW-1 -: LB] == LB'(l))
            lane_q[wr_col[OB-1:0]] <= wr_bit;
      end
      assign row_bits[l*DEPTH +: DEPTH] = lane_q;
      assign lane_out[l] = lane_q[rd_col[OB-1:0]];
   end

   assign rd_bit = lane_out[rd_col[CW-1 -: LB]];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lrr       <= '0;
         lrr_valid <= 1'b0;
      end else if (fill) begin
         lrr       <= fill_row;
         lrr_valid <= 1'b1;
      end
   end
endmodule

// File: rtl/cdr_strobe_decode.sv
module cdr_strobe_decode import cdr_pkg::*; #(
   parameter int RECOV = 2
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    row_en_n,
   input  logic    rfsh_n,
   input  logic    wr_mode,
   input  logic    sel_n,
   input  logic    row_hit,
   output cdr_op_e mode,
   output logic    fall,
   output logic    fill,
   output logic    wr_hit,
   output logic    blk
);
   localparam int CNTW = $clog2(RECOV + 1);

   logic            row_en_q;
   logic            accept;
   logic [CNTW-1:0] cnt_q;

   assign fall   = row_en_q & ~row_en_n;
   assign accept = fall & (~sel_n | ~rfsh_n);
   assign fill   = accept & rfsh_n & ~wr_mode & ~row_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_en_q <= 1'b1;
         mode     <= OP_IDLE;
         wr_hit   <= 1'b0;
         blk      <= 1'b0;
         cnt_q    <= '0;
      end else begin
         row_en_q <= row_en_n;
         if (accept) begin
            mode   <= !rfsh_n ? OP_RFSH : (wr_mode ? OP_WRITE : OP_READ);
            wr_hit <= rfsh_n & wr_mode & row_hit;
            blk    <= rfsh_n & wr_mode & ~row_hit;
            cnt_q  <= '0;
         end else if (row_en_n) begin
            mode   <= OP_IDLE;
            wr_hit <= 1'b0;
            if (blk) begin
               if (cnt_q == CNTW'(RECOV - 1)) blk <= 1'b0;
               else                           cnt_q <= cnt_q + CNTW'(1);
            end
         end
      end
   end

   // R8: the block only ends with row-enable high or on a new accepted fall
   a_r8_release_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(blk) |-> ($past(row_en_n) || $past(fall)));
endmodule

// File: rtl/cdr_row_ctrl.sv
module cdr_row_ctrl import cdr_pkg::*; #(
   parameter int ROWS  = 16,
   parameter int COLS  = 16,
   parameter int LANES = 4,
   parameter int RECOV = 2,
   localparam int RW   = $clog2(ROWS),
   localparam int CW   = $clog2(COLS),
   localparam int AW   = (RW > CW) ? RW : CW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          row_en_n,
   input  logic          rfsh_n,
   input  logic          wr_mode,
   input  logic          sel_n,
   input  logic          col_lat_n,
   input  logic          we_n,
   input  logic          oe_n,
   input  logic [AW-1:0] addr,
   input  logic          din,
   output logic          dout,
   output logic          dout_en
);
   if (ROWS < 2 || (ROWS & (ROWS - 1)) != 0) begin : g_bad_rows
      $error("ROWS must be a power of two of at least 2");
   end
   if (LANES < 2 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
      $error("LANES must be a power of two of at least 2");
   end
   if ((COLS & (COLS - 1)) != 0 || COLS < 2 * LANES) begin : g_bad_cols
      $error("COLS must be a power of two holding at least two bits per lane");
   end
   if (RECOV < 1) begin : g_bad_recov
      $error("RECOV must be at least 1");
   end

   logic [RW-1:0]   row_in, row_q, lrr;
   logic [CW-1:0]   col_in, col_hold, col_eff;
   logic [COLS-1:0] fill_bits, row_bits;
   cdr_op_e         mode;
   logic            fall, fill, wr_hit, blk, row_hit, lrr_valid;
   logic            arr_we, cache_we, rd_bit;

   assign row_in  = addr[RW-1:0];
   assign col_in  = addr[CW-1:0];
   assign col_eff = col_lat_n ? col_in : col_hold;
   assign row_hit = lrr_valid && (lrr == row_in);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col_hold <= '0;
         row_q    <= '0;
      end else begin
         if (col_lat_n) col_hold <= col_in;
         if (fall)      row_q    <= row_in;
      end
   end

   cdr_strobe_decode #(.RECOV(RECOV)) u_decode (
      .clk(clk), .rst_n(rst_n), .row_en_n(row_en_n), .rfsh_n(rfsh_n),
      .wr_mode(wr_mode), .sel_n(sel_n), .row_hit(row_hit), .mode(mode),
      .fall(fall), .fill(fill), .wr_hit(wr_hit), .blk(blk)
   );

   assign arr_we   = (mode == OP_WRITE) && !row_en_n && !col_lat_n && !we_n;
   assign cache_we = arr_we && wr_hit;

   cdr_core_array #(.ROWS(ROWS), .COLS(COLS)) u_array (
      .clk(clk), .rst_n(rst_n), .we(arr_we), .wr_row(row_q), .wr_col(col_eff),
      .wr_bit(din), .rd_row(row_in), .rd_bits(fill_bits)
   );

   cdr_row_cache #(.COLS(COLS), .LANES(LANES), .RW(RW)) u_cache (
      .clk(clk), .rst_n(rst_n), .fill(fill), .fill_row(row_in),
      .fill_bits(fill_bits), .wr_en(cache_we), .wr_col(col_eff), .wr_bit(din),
      .rd_col(col_eff), .rd_bit(rd_bit), .lrr(lrr), .lrr_valid(lrr_valid),
      .row_bits(row_bits)
   );

   assign dout_en = !sel_n && !oe_n && !blk;
   assign dout    = dout_en & rd_bit;

   // R5: a write hit leaves the written bit in the row register
   a_r5_write_hit_coherent: assert property (@(posedge clk) disable iff (!rst_n)
      cache_we |=> (row_bits[$past(col_eff)] == $past(din)));
   // R6: a core-only write does not touch the row register
   a_r6_miss_keeps_row: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_we && !wr_hit) |=> $stable(row_bits));
   // R7: without both strobes low the row register is untouched
   a_r7_needs_both_strobes: assert property (@(posedge clk) disable iff (!rst_n)
      (!row_en_n && !fall && (col_lat_n || we_n)) |=> $stable(row_bits));
   // R8: a write-miss start blocks the output next cycle
   a_r8_block_after_miss: assert property (@(posedge clk) disable iff (!rst_n)
      (fall && !sel_n && rfsh_n && wr_mode && !row_hit) |=> !dout_en);
   // R11: deselected non-refresh cycles change nothing
   a_r11_standby_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (fall && sel_n && rfsh_n) |=> ($stable(lrr) && $stable(row_bits)));
   // R2: refresh keeps the tag
   a_r2_refresh_keeps_tag: assert property (@(posedge clk) disable iff (!rst_n)
      (fall && !rfsh_n) |=> $stable(lrr));
endmodule

// File: tb/cdr_row_ctrl_bench.sv
`timescale 1ns/1ps
module cdr_row_ctrl_bench;
   localparam int ROWS = 16, COLS = 16, LANES = 4, RECOV = 2;
   localparam int AW = 4;

   logic clk = 1'b0, rst_n = 1'b0;
   logic row_en_n, rfsh_n, wr_mode, sel_n, col_lat_n, we_n, oe_n, din;
   logic [AW-1:0] addr;
   logic dout, dout_en;

   always #2 clk = ~clk;

   cdr_row_ctrl #(.ROWS(ROWS), .COLS(COLS), .LANES(LANES), .RECOV(RECOV)) u_cdr_row_ctrl (
      .clk(clk), .rst_n(rst_n), .row_en_n(row_en_n), .rfsh_n(rfsh_n), .wr_mode(wr_mode),
      .sel_n(sel_n), .col_lat_n(col_lat_n), .we_n(we_n), .oe_n(oe_n), .addr(addr),
      .din(din), .dout(dout), .dout_en(dout_en)
   );

   // reference model built from the requirements
   logic [COLS-1:0] m_arr [ROWS];
   logic [COLS-1:0] m_cache;
   logic [AW-1:0]   m_lrr, m_row_q, m_col_hold;
   logic            m_valid, m_whit, m_blk, m_prev_re;
   int              m_mode, m_cnt;
   int              checks = 0, errors = 0;
   bit              done = 0;

   task automatic ref_edge();
      logic [AW-1:0] ce = col_lat_n ? addr : m_col_hold;
      bit fall = m_prev_re && !row_en_n;
      bit hit;
      if (!fall && m_mode == 2 && !row_en_n && !col_lat_n && !we_n) begin
         m_arr[m_row_q][ce] = din;
         if (m_whit) m_cache[ce] = din;
      end
      if (fall && (!sel_n || !rfsh_n)) begin
         hit = m_valid && (m_lrr == addr);
         m_row_q = addr; m_cnt = 0;
         if (!rfsh_n) begin m_mode = 3; m_whit = 0; m_blk = 0; end
         else if (!wr_mode) begin
            m_mode = 1; m_whit = 0; m_blk = 0;
            if (!hit) begin m_cache = m_arr[addr]; m_lrr = addr; m_valid = 1; end
         end else begin m_mode = 2; m_whit = hit; m_blk = !hit; end
      end else if (row_en_n) begin
         m_mode = 0; m_whit = 0;
         if (m_blk) begin
            if (m_cnt == RECOV - 1) m_blk = 0; else m_cnt++;
         end
      end
      if (col_lat_n) m_col_hold = addr;
      m_prev_re = row_en_n;
   endtask

   task automatic tick();
      @(posedge clk);
      if (rst_n) ref_edge();
      #1;
   endtask

   task automatic check_out(input string req);
      logic [AW-1:0] ce;
      logic exp_en, exp_d;
      @(negedge clk);
      ce = col_lat_n ? addr : m_col_hold;
      exp_en = !sel_n && !oe_n && !m_blk;
      exp_d  = exp_en ? m_cache[ce] : 1'b0;
      checks++;
      if (dout_en !== exp_en || dout !== exp_d) begin
         errors++;
         $display("FAIL %s: dout_en=%0b dout=%0b expected dout_en=%0b dout=%0b",
                  req, dout_en, dout, exp_en, exp_d);
      end
   endtask

   task automatic idle_inputs();
      row_en_n = 1; rfsh_n = 1; wr_mode = 0; sel_n = 0;
      col_lat_n = 1; we_n = 1; oe_n = 0; din = 0; addr = '0;
   endtask

   task automatic op_read(input logic [AW-1:0] row);
      wr_mode = 0; addr = row; row_en_n = 0; tick();
      row_en_n = 1; tick();
   endtask

   task automatic op_write(input logic [AW-1:0] row, input logic [AW-1:0] col,
                           input logic bitv, input string req, input bit chk);
      wr_mode = 1; addr = row; row_en_n = 0; tick();
      addr = col; tick();
      col_lat_n = 0; we_n = 0; din = bitv; tick();
      if (chk) check_out(req);
      col_lat_n = 1; we_n = 1; row_en_n = 1; wr_mode = 0; tick();
   endtask

   task automatic row_check(input string req);
      for (int c = 0; c < COLS; c++) begin
         addr = AW'(c); check_out(req);
      end
   endtask

   initial begin
      void'($urandom(32'd4242));
      idle_inputs();
      for (int r = 0; r < ROWS; r++) m_arr[r] = '0;
      m_cache = '0; m_lrr = '0; m_row_q = '0; m_col_hold = '0;
      m_valid = 0; m_whit = 0; m_blk = 0; m_prev_re = 1; m_mode = 0; m_cnt = 0;
      repeat (3) tick();
      rst_n = 1; tick();

      // R1: reset state, then row 0 is a miss despite the cleared tag
      addr = 4'd3; check_out("R1 reset output");
      op_write(4'd0, 4'd2, 1'b1, "R1 first access misses", 1);
      tick(); tick();
      addr = 4'd2; check_out("R1 row register still clear");

      // load the core with random data through write misses
      for (int r = 0; r < ROWS; r++)
         for (int c = 0; c < COLS; c++)
            op_write(AW'(r), AW'(c), 1'($urandom), "", 0);
      tick(); tick();

      op_read(4'd5);  row_check("R3 read miss fill");
      op_read(4'd5);  row_check("R4 read hit");
      op_write(4'd5, 4'd9, ~m_cache[9], "R5 read during write hit", 1);
      addr = 4'd9; check_out("R5 write hit visible");

      // R8 / R6: write miss blocks output, then releases after RECOV edges
      op_write(4'd9, 4'd3, ~m_arr[9][3], "R8 blocked during write miss", 1);
      addr = 4'd3; check_out("R8 still blocked after rise");
      tick(); check_out("R8 released");
      row_check("R6 row register unchanged");
      op_read(4'd9); addr = 4'd3; check_out("R6 miss data after refill");

      // R7: each strobe alone writes nothing
      wr_mode = 1; addr = 4'd9; row_en_n = 0; tick();
      addr = 4'd4; tick();
      we_n = 0; din = ~m_cache[4]; tick();
      we_n = 1; col_lat_n = 0; tick();
      col_lat_n = 1; row_en_n = 1; wr_mode = 0; tick();
      row_check("R7 single strobe no write");

      // R9: gating with row-enable inactive
      addr = 4'd4; oe_n = 1; check_out("R9 output enable high");
      oe_n = 0; sel_n = 1; check_out("R9 select high");
      sel_n = 0; check_out("R9 enabled");

      // R10: column hold
      op_write(4'd9, 4'd6, 1'b1, "R10 setup", 1);
      op_write(4'd9, 4'd1, 1'b0, "R10 setup", 1);
      addr = 4'd6; tick();
      col_lat_n = 0; addr = 4'd1; check_out("R10 held column");
      col_lat_n = 1; check_out("R10 transparent column");

      // R11: deselected read and write are ignored
      sel_n = 1; op_read(4'd2);
      op_write(4'd9, 4'd6, 1'b0, "", 0);
      sel_n = 0; row_check("R11 standby ignored");
      op_read(4'd9); row_check("R11 core untouched");

      // R2: refresh with read mode and another row
      rfsh_n = 0; wr_mode = 0; addr = 4'd3; row_en_n = 0; tick();
      row_en_n = 1; rfsh_n = 1; tick();
      row_check("R2 refresh no fill");

      // random mix
      for (int i = 0; i < 400; i++) begin
         case ($urandom % 5)
            0, 1: op_read(AW'($urandom));
            2, 3: op_write(AW'($urandom), AW'($urandom), 1'($urandom), "R5 random write", 1);
            default: begin
               rfsh_n = 0; addr = AW'($urandom); row_en_n = 0; tick();
               row_en_n = 1; rfsh_n = 1; tick();
            end
         endcase
         oe_n = ($urandom % 8) == 0;
         addr = AW'($urandom); check_out("R9 random read");
         oe_n = 0;
      end
      repeat (4) tick();
      row_check("R4 final row register");

      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         done = 1;
         checks++; errors++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule